// File: doc/BRIEF.md
# Two-Stage Egress Packet Arbiter

This block decides which waiting packet leaves one egress port of a packet switch in each cycle. Every ingress port raises a request per traffic class (8 classes). A programmable table assigns each class to a virtual channel. The arbiter works in two stages. In the first stage, each virtual channel picks one ingress port round-robin among the ports that have a packet for it. Inside that port it picks one class round-robin among the classes that share the channel. In the second stage, a strict-priority selector chooses one channel among the channel candidates. Each channel's priority is set by a small configuration field.

The decision is registered. One grant leaves the block per cycle, one cycle after the request pattern that produced it. The grant comes both as a one-hot vector over all (port, class) request lines and as decoded port, class and channel indices. A build with a single ingress source keeps no port rotation state and reduces to class rotation plus channel selection.

Top module: `twostage_egress_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, no grant is issued. All rotation pointers start at port 0 and class 0.
- R2: The class-to-channel table holds a 3-bit channel index for class c at bits [3c+2:3c] of `tc_map_i`. A granted request always reports the channel that the table gave its class in the deciding cycle.
- R3: Within one channel, ingress ports are served round-robin. After port p is granted, the search for that channel starts at port p+1 and wraps at N_PORTS.
- R4: Only the winning channel's rotation pointers move. A channel whose candidate lost the second stage keeps its port and class pointers.
- R5: Channel priority is strict. The 3-bit priority of channel v sits at bits [3v+2:3v] of `vc_prio_i`, and the channel with the larger value wins.
- R6: Among candidate channels with equal priority, the lower channel number wins.
- R7: Classes of one port that map to the same channel are served round-robin. After class c is granted on a channel, that channel's class search starts at c+1 and wraps at 8.
- R8: The grant is registered. Outputs in a cycle reflect the requests sampled at the previous clock edge. At most one grant is issued per cycle, and `gnt_vec_o` has only bit p*8+c set for port p and class c.
- R9: Requests whose class maps to a channel index of N_VC or above are never granted. A cycle with no grantable request produces no grant, and a cycle with one produces a grant.
- R10: With N_PORTS = 1, grants always name port 0, and class rotation and channel priority still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_PORTS*8 | Request line for port p, class c at bit p*8+c |
| tc_map_i | input | 24 | Channel index per class, 3 bits each |
| vc_prio_i | input | N_VC*3 | Priority value per channel, 3 bits each |
| gnt_valid_o | output | 1 | A grant is issued this cycle |
| gnt_vec_o | output | N_PORTS*8 | One-hot grant over the request lines |
| gnt_port_o | output | 3 | Granted ingress port |
| gnt_tc_o | output | 3 | Granted traffic class |
| gnt_vc_o | output | 3 | Channel of the granted class |

## Verification
The assertions assume that the request, table and priority inputs are stable around the clock edge. They also assume that the same inputs are what the arbiter sampled, and they compare each grant against registered copies of those inputs. The stimulus changes inputs only a short time after each rising edge. It allows table entries that point past the last channel, so that the unmapped-class path is exercised and not assumed away. Requests are level-held with no acknowledgement loop, so a request may be granted again on the following cycle. The stimulus never relies on a request dropping after its grant.

// File: rtl/ea2_pkg.sv
package ea2_pkg;

    localparam int TC_N     = 8;
    localparam int TC_W     = 3;
    localparam int VC_W     = 3;
    localparam int PRIO_W   = 3;
    localparam int LANE_MAX = 8;

    typedef logic [TC_W-1:0] tc_t;
    typedef logic [VC_W-1:0] vc_t;

    typedef struct packed {
        logic       found;
        logic [2:0] idx;
    } pick_t;

    typedef struct packed {
        logic       valid;
        logic [2:0] port;
        tc_t        tc;
    } cand_t;

    // First set bit of vec at or after ptr, wrapping at n (n <= LANE_MAX).
    function automatic pick_t rr_first(input logic [LANE_MAX-1:0] vec,
                                       input int n,
                                       input logic [2:0] ptr);
        pick_t r;
        int    j;
        r = '0;
        for (int i = LANE_MAX - 1; i >= 0; i--) begin
            if (i < n) begin
                j = int'(ptr) + i;
                if (j >= n) j = j - n;
                if (vec[3'(j)]) begin
                    r.found = 1'b1;
                    r.idx   = 3'(j);
                end
            end
        end
        return r;
    endfunction

    function automatic logic [2:0] wrap_inc(input logic [2:0] idx, input int n);
        int nx;
        nx = int'(idx) + 1;
        if (nx >= n) nx = 0;
        return 3'(nx);
    endfunction

endpackage

// File: rtl/ea2_vc_lane.sv
module ea2_vc_lane
    import ea2_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int VC_ID   = 0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_PORTS*TC_N-1:0] req_i,
    input  logic [TC_N*VC_W-1:0]    map_i,
    input  logic                    win_i,
    output cand_t                   cand_o
);

    logic [N_PORTS-1:0][TC_N-1:0] hit;
    logic [LANE_MAX-1:0]          port_any;
    logic [LANE_MAX-1:0]          cls_vec;
    logic [2:0]                   cls_ptr_q;
    pick_t                        port_pick;
    pick_t                        cls_pick;

    // Requests that belong to this channel
    always_comb begin
        port_any = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            for (int c = 0; c < TC_N; c++) begin
                hit[p][c] = req_i[p*TC_N + c] &&
                            (map_i[c*VC_W +: VC_W] == VC_W'(VC_ID));
            end
            port_any[p] = |hit[p];
        end
    end

    // Port stage: a single source needs no rotation state
    generate
        if (N_PORTS == 1) begin : g_single
            always_comb port_pick = rr_first(port_any, 1, 3'd0);
        end else begin : g_multi
            logic [2:0] port_ptr_q;
            always_comb port_pick = rr_first(port_any, N_PORTS, port_ptr_q);
            always_ff @(posedge clk) begin
                if (rst)
                    port_ptr_q <= 3'd0;
                else if (win_i)
                    port_ptr_q <= wrap_inc(port_pick.idx, N_PORTS);
            end
        end
    endgenerate

    // Class stage inside the chosen port
    always_comb begin
        cls_vec = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            if (3'(p) == port_pick.idx) cls_vec = hit[p];
        end
        cls_pick = rr_first(cls_vec, TC_N, cls_ptr_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cls_ptr_q <= 3'd0;
        else if (win_i)
            cls_ptr_q <= wrap_inc(cls_pick.idx, TC_N);
    end

    always_comb begin
        cand_o.valid = port_pick.found;
        cand_o.port  = port_pick.idx;
        cand_o.tc    = cls_pick.idx;
    end

endmodule

// File: rtl/ea2_vc_select.sv
module ea2_vc_select
    import ea2_pkg::*;
#(
    parameter int N_VC = 4
) (
    input  cand_t                    cand_i [N_VC],
    input  logic [N_VC*PRIO_W-1:0]   prio_i,
    output logic                     win_valid_o,
    output vc_t                      win_vc_o
);

    logic [PRIO_W-1:0] best;

    // Strict priority; the strict compare keeps the lower index on ties
    always_comb begin
        win_valid_o = 1'b0;
        win_vc_o    = '0;
        best        = '0;
        for (int v = 0; v < N_VC; v++) begin
            if (cand_i[v].valid &&
                (!win_valid_o || prio_i[v*PRIO_W +: PRIO_W] > best)) begin
                win_valid_o = 1'b1;
                win_vc_o    = VC_W'(v);
                best        = prio_i[v*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/twostage_egress_arb.sv
module twostage_egress_arb
    import ea2_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int N_VC    = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PORTS*TC_N-1:0]   req_i,
    input  logic [TC_N*VC_W-1:0]      tc_map_i,
    input  logic [N_VC*PRIO_W-1:0]    vc_prio_i,
    output logic                      gnt_valid_o,
    output logic [N_PORTS*TC_N-1:0]   gnt_vec_o,
    output logic [2:0]                gnt_port_o,
    output logic [TC_W-1:0]           gnt_tc_o,
    output logic [VC_W-1:0]           gnt_vc_o
);

    localparam int LINES = N_PORTS * TC_N;

    cand_t             cand [N_VC];
    cand_t             sel;
    logic              sel_valid;
    vc_t               sel_vc;
    logic [LINES-1:0]  vec_d;

    generate
        for (genvar v = 0; v < N_VC; v++) begin : g_lane
            ea2_vc_lane #(
                .N_PORTS (N_PORTS),
                .VC_ID   (v)
            ) u_lane (
                .clk    (clk),
                .rst    (rst),
                .req_i  (req_i),
                .map_i  (tc_map_i),
                .win_i  (sel_valid && (sel_vc == VC_W'(v))),
                .cand_o (cand[v])
            );
        end
    endgenerate

    ea2_vc_select #(
        .N_VC (N_VC)
    ) u_select (
        .cand_i      (cand),
        .prio_i      (vc_prio_i),
        .win_valid_o (sel_valid),
        .win_vc_o    (sel_vc)
    );

    always_comb begin
        sel = '0;
        for (int v = 0; v < N_VC; v++) begin
            if (sel_vc == VC_W'(v)) sel = cand[v];
        end
        vec_d = '0;
        for (int i = 0; i < LINES; i++) begin
            if (sel_valid && (i == int'(sel.port) * TC_N + int'(sel.tc)))
                vec_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_valid_o <= 1'b0;
            gnt_vec_o   <= '0;
            gnt_port_o  <= '0;
            gnt_tc_o    <= '0;
            gnt_vc_o    <= '0;
        end else begin
            gnt_valid_o <= sel_valid;
            gnt_vec_o   <= vec_d;
            gnt_port_o  <= sel_valid ? sel.port : 3'd0;
            gnt_tc_o    <= sel_valid ? sel.tc   : '0;
            gnt_vc_o    <= sel_valid ? sel_vc   : '0;
        end
    end

endmodule

// File: rtl/ea2_chk.sv
module ea2_chk
    import ea2_pkg::*;
#(
    parameter int N_PORTS = 4,
    parameter int N_VC    = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_PORTS*TC_N-1:0]   req_i,
    input logic [TC_N*VC_W-1:0]      tc_map_i,
    input logic [N_VC*PRIO_W-1:0]    vc_prio_i,
    input logic                      gnt_valid_o,
    input logic [N_PORTS*TC_N-1:0]   gnt_vec_o,
    input logic [2:0]                gnt_port_o,
    input logic [TC_W-1:0]           gnt_tc_o,
    input logic [VC_W-1:0]           gnt_vc_o
);

    logic                      armed;
    logic [N_PORTS*TC_N-1:0]   q_req;
    logic [TC_N*VC_W-1:0]      q_map;
    logic [N_VC*PRIO_W-1:0]    q_prio;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            q_req  <= '0;
            q_map  <= '0;
            q_prio <= '0;
        end else begin
            armed  <= 1'b1;
            q_req  <= req_i;
            q_map  <= tc_map_i;
            q_prio <= vc_prio_i;
        end
    end

    logic              req_hit;
    logic              vec_hit;
    logic              pend_any;
    logic              higher;
    logic [VC_W-1:0]   map_of_tc;
    logic [PRIO_W-1:0] gnt_prio;

    always_comb begin
        req_hit   = 1'b0;
        vec_hit   = 1'b0;
        pend_any  = 1'b0;
        higher    = 1'b0;
        map_of_tc = '0;
        gnt_prio  = '0;
        for (int c = 0; c < TC_N; c++)
            if (gnt_tc_o == TC_W'(c)) map_of_tc = q_map[c*VC_W +: VC_W];
        for (int v = 0; v < N_VC; v++)
            if (gnt_vc_o == VC_W'(v)) gnt_prio = q_prio[v*PRIO_W +: PRIO_W];
        for (int p = 0; p < N_PORTS; p++) begin
            for (int c = 0; c < TC_N; c++) begin
                if (gnt_port_o == 3'(p) && gnt_tc_o == TC_W'(c)) begin
                    req_hit = q_req[p*TC_N + c];
                    vec_hit = gnt_vec_o[p*TC_N + c];
                end
                if (q_req[p*TC_N + c] && int'(q_map[c*VC_W +: VC_W]) < N_VC) begin
                    pend_any = 1'b1;
                    for (int v = 0; v < N_VC; v++)
                        if (q_map[c*VC_W +: VC_W] == VC_W'(v) &&
                            q_prio[v*PRIO_W +: PRIO_W] > gnt_prio)
                            higher = 1'b1;
                end
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> !gnt_valid_o);

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        $onehot0(gnt_vec_o) && (gnt_valid_o == (gnt_vec_o != '0)));

    assert_vec_index_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        gnt_valid_o |-> vec_hit);

    assert_granted_was_requested_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        gnt_valid_o |-> req_hit);

    assert_channel_from_table_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        gnt_valid_o |-> (gnt_vc_o == map_of_tc));

    assert_channel_exists_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        gnt_valid_o |-> (int'(gnt_vc_o) < N_VC));

    assert_work_conserving_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        gnt_valid_o == pend_any);

    assert_strict_priority_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        gnt_valid_o |-> !higher);

endmodule

bind twostage_egress_arb ea2_chk #(
    .N_PORTS (N_PORTS),
    .N_VC    (N_VC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .tc_map_i    (tc_map_i),
    .vc_prio_i   (vc_prio_i),
    .gnt_valid_o (gnt_valid_o),
    .gnt_vec_o   (gnt_vec_o),
    .gnt_port_o  (gnt_port_o),
    .gnt_tc_o    (gnt_tc_o),
    .gnt_vc_o    (gnt_vc_o)
);

// File: tb/twostage_egress_arb_tb_top.sv
module twostage_egress_arb_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NV = 4;
    localparam int NC = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NP*NC-1:0] req  = '0;
    logic [NC*3-1:0]  map  = '0;
    logic [NV*3-1:0]  prio = '0;
    logic             g_valid;
    logic [NP*NC-1:0] g_vec;
    logic [2:0]       g_port, g_tc, g_vc;

    logic [NC-1:0]    req1  = '0;
    logic [NC*3-1:0]  map1  = '0;
    logic [5:0]       prio1 = '0;
    logic             g1_valid;
    logic [NC-1:0]    g1_vec;
    logic [2:0]       g1_port, g1_tc, g1_vc;

    twostage_egress_arb #(.N_PORTS(NP), .N_VC(NV)) dut_i (
        .clk(clk), .rst(rst), .req_i(req), .tc_map_i(map), .vc_prio_i(prio),
        .gnt_valid_o(g_valid), .gnt_vec_o(g_vec), .gnt_port_o(g_port),
        .gnt_tc_o(g_tc), .gnt_vc_o(g_vc));

    twostage_egress_arb #(.N_PORTS(1), .N_VC(2)) dut1_i (
        .clk(clk), .rst(rst), .req_i(req1), .tc_map_i(map1), .vc_prio_i(prio1),
        .gnt_valid_o(g1_valid), .gnt_vec_o(g1_vec), .gnt_port_o(g1_port),
        .gnt_tc_o(g1_tc), .gnt_vc_o(g1_vc));

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string tag = "R1";

    // reference state: next search start per channel
    int pp [NV];
    int cp [NV];
    int e_valid, e_port, e_tc, e_vc;

    task automatic check(string r, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    function automatic int map_of(int c);
        return int'(map[c*3 +: 3]);
    endfunction

    function automatic int prio_of(int v);
        return int'(prio[v*3 +: 3]);
    endfunction

    task automatic predict();
        int okv [NV];
        int cpt [NV];
        int ccl [NV];
        int best;
        for (int v = 0; v < NV; v++) begin
            okv[v] = 0; cpt[v] = 0; ccl[v] = 0;
            for (int i = 0; i < NP && okv[v] == 0; i++) begin
                int p = (pp[v] + i) % NP;
                for (int c = 0; c < NC; c++)
                    if (req[p*NC + c] && map_of(c) == v) okv[v] = 1;
                if (okv[v] == 1) cpt[v] = p;
            end
            if (okv[v] == 1) begin
                for (int i = NC - 1; i >= 0; i--) begin
                    int c = (cp[v] + i) % NC;
                    if (req[cpt[v]*NC + c] && map_of(c) == v) ccl[v] = c;
                end
            end
        end
        best = -1;
        for (int v = 0; v < NV; v++)
            if (okv[v] == 1 && (best < 0 || prio_of(v) > prio_of(best))) best = v;
        e_valid = (best >= 0) ? 1 : 0;
        e_vc    = (best >= 0) ? best : 0;
        e_port  = (best >= 0) ? cpt[best] : 0;
        e_tc    = (best >= 0) ? ccl[best] : 0;
    endtask

    // one clock: predict from current inputs, sample after the edge, compare
    task automatic step();
        logic [NP*NC-1:0] ev;
        predict();
        @(posedge clk);
        #2;
        ev = '0;
        if (e_valid == 1) ev[e_port*NC + e_tc] = 1'b1;
        check(tag, "gnt_valid", g_valid, e_valid);
        check(tag, "gnt_vec", g_vec, ev);
        if (e_valid == 1) begin
            check(tag, "gnt_port", g_port, e_port);
            check(tag, "gnt_tc", g_tc, e_tc);
            check(tag, "gnt_vc", g_vc, e_vc);
            check("R2", "vc_from_table", g_vc, map_of(int'(g_tc)));
            pp[e_vc] = (e_port + 1) % NP;
            cp[e_vc] = (e_tc + 1) % NC;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int v = 0; v < NV; v++) begin pp[v] = 0; cp[v] = 0; end

        // R1: reset state
        rst = 1'b1;
        req = '1;
        req1 = '1;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "valid_in_reset", g_valid, 0);
        check("R1", "vec_in_reset", g_vec, 0);
        check("R1", "single_valid_in_reset", g1_valid, 0);
        req = '0; req1 = '0;
        rst = 1'b0;
        tag = "R1";
        step();

        // R3: ports 0,2,3 on class 0, all classes on channel 0
        tag = "R3";
        req[0*NC + 0] = 1'b1; req[2*NC + 0] = 1'b1; req[3*NC + 0] = 1'b1;
        step(); check("R3", "port_seq0", g_port, 0);
        step(); check("R3", "port_seq1", g_port, 2);
        step(); check("R3", "port_seq2", g_port, 3);
        step(); check("R3", "port_seq3", g_port, 0);

        // R7: port 1 classes 2 and 5 share channel 0
        tag = "R7";
        req = '0;
        req[1*NC + 2] = 1'b1; req[1*NC + 5] = 1'b1;
        step(); check("R7", "class_seq0", g_tc, 2);
        step(); check("R7", "class_seq1", g_tc, 5);
        step(); check("R7", "class_seq2", g_tc, 2);

        // R5: channel 3 at priority 5 beats channel 0 at priority 1
        tag = "R5";
        req = '0;
        map[6*3 +: 3] = 3'd3;
        prio[3*3 +: 3] = 3'd5; prio[0*3 +: 3] = 3'd1;
        req[0*NC + 0] = 1'b1; req[3*NC + 6] = 1'b1;
        step(); check("R5", "high_vc_wins", g_vc, 3);
        check("R5", "high_vc_port", g_port, 3);

        // R6: equal priority, lower channel wins
        tag = "R6";
        prio[3*3 +: 3] = 3'd1;
        step(); check("R6", "tie_lower_vc", g_vc, 0);
        check("R6", "tie_port", g_port, 0);

        // R4: losing channel 0 keeps its pointer (now at port 1)
        tag = "R4";
        req = '0; prio = '0;
        map[3*3 +: 3] = 3'd1;
        prio[1*3 +: 3] = 3'd6;
        req[2*NC + 3] = 1'b1; req[1*NC + 0] = 1'b1; req[3*NC + 0] = 1'b1;
        step(); check("R4", "vc1_first", g_vc, 1);
        step(); check("R4", "vc1_again", g_vc, 1);
        req[2*NC + 3] = 1'b0;
        step(); check("R4", "vc0_ptr_kept", g_port, 1);

        // R9: class 5 mapped past the last channel
        tag = "R9";
        req = '0;
        map[5*3 +: 3] = 3'd6;
        req[0*NC + 5] = 1'b1;
        step(); check("R9", "unmapped_no_grant", g_valid, 0);
        req[1*NC + 0] = 1'b1;
        step(); check("R9", "mapped_granted", g_tc, 0);
        req = '0;
        step(); check("R9", "idle_no_grant", g_valid, 0);

        // R10: single-source build
        tag = "R10";
        map1 = '0; map1[7*3 +: 3] = 3'd1;
        prio1[1*3 +: 3] = 3'd4; prio1[0*3 +: 3] = 3'd2;
        req1 = '0; req1[0] = 1'b1; req1[7] = 1'b1;
        step();
        check("R10", "single_vc", g1_vc, 1);
        check("R10", "single_tc", g1_tc, 7);
        check("R10", "single_port", g1_port, 0);
        req1 = '0; req1[0] = 1'b1; req1[3] = 1'b1;
        step(); check("R10", "single_rot0", g1_tc, 0);
        step(); check("R10", "single_rot1", g1_tc, 3);
        step(); check("R10", "single_rot2", g1_tc, 0);
        check("R10", "single_vec", g1_vec, 8'h01);
        req1 = '0;

        // R8: mixed random traffic compared every cycle
        tag = "R8";
        for (int n = 0; n < 3000; n++) begin
            if (n % 50 == 0) begin
                map  = 24'($urandom);
                prio = 12'($urandom);
            end
            req = 32'($urandom) & 32'($urandom) & 32'($urandom);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule